// File: doc/BRIEF.md
# Circular-Hint Page Bitmap Allocator

This block hands out and takes back ranges of I/O virtual pages. It keeps one bit per page in an internal bitmap. A set bit marks a page as in use, and lower bit positions stand for lower page addresses. An allocate request carries a page count. The block rounds that count up to an aligned power-of-two chunk of 8, 16, 32 or 64 pages. It then searches for a fully clear chunk of that size and returns the chunk's first page index.

The search looks at one aligned chunk per clock. It begins at a rotating hint, rounded down to the chunk size, and moves toward the top of the map. If it reaches the end, it wraps to page 0 and continues until every chunk of that size has been examined. Each grant moves the hint just past the granted chunk, so that short-lived mappings spread across the map.

A free request names a page index and a size class, and clears that chunk's bits in one cycle. Results are reported as one-cycle `done` or `error` pulses. `busy` is high while a search runs.

Top module: `pgalloc_top`

## Requirements
- R1: After reset `busy`, `done` and `error` are low, every page is free and the hint is page 0.
- R2: On `done`, `grant_idx` is the lowest page index of the granted chunk, and every page of that chunk reads as in use for later searches.
- R3: A request of 1–8 pages takes an aligned 8-page chunk, 9–16 a 16-page chunk, 17–32 a 32-page chunk and 33–64 a 64-page chunk, so `grant_idx` is a multiple of the chunk size.
- R4: A request for 0 pages, or for more than 64 pages, raises `error` for one cycle right after the request edge. `busy` stays low, and neither the bitmap nor the hint changes.
- R5: The search starts at the hint rounded down to the chunk size and moves upward. After the last chunk of the map it continues from chunk 0, and it examines each chunk at most once.
- R6: A chunk is granted only if all of its pages are free. The first such chunk found by the search is the one granted.
- R7: After a grant, the hint becomes the page just past the granted chunk, or 0 if that is the end of the map. An error leaves the hint unchanged.
- R8: If no chunk of the requested size is free, `error` pulses after every chunk of that size has been examined: 1 + MAP_PAGES/size cycles after the request edge.
- R9: One chunk is examined per clock. A grant found at the j-th chunk examined gives `done` 1 + j cycles after the request edge, and `busy` stays high in between.
- R10: A free request with `free_cls` (0 = 8, 1 = 16, 2 = 32, 3 = 64 pages) clears, in one cycle, the aligned chunk that holds `free_idx`. It leaves the hint unchanged.
- R11: `alloc_req` is ignored while `busy` is high. `free_req` is ignored while `busy` or `alloc_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Allocate request, sampled when not busy |
| alloc_pages | input | CNT_W | Number of pages requested |
| free_req | input | 1 | Free request |
| free_idx | input | IDX_W | Any page index inside the chunk to free |
| free_cls | input | 2 | Size class of the chunk to free |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle grant pulse |
| error | output | 1 | One-cycle pulse for a bad request or no free chunk |
| grant_idx | output | IDX_W | First page of the granted chunk, valid with `done` |

## Verification
A wrong bit in the bitmap stays hidden until a search reaches its chunk. It then shows up as a skipped or doubly granted index, or as a false out-of-resources error. Such a fault can go unseen for many requests. For that reason the sequence fills, frees and re-fills chunks of mixed sizes, so that stale bits are eventually crossed. A wrong hint or start alignment shows up on the very next grant, both in its index and in its latency. Each request's cycle count is therefore checked as closely as its index.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;
   typedef enum logic [1:0] {
      CLS_8  = 2'd0,
      CLS_16 = 2'd1,
      CLS_32 = 2'd2,
      CLS_64 = 2'd3
   } chunk_cls_e;

   localparam int unsigned NUM_CLS   = 4;
   localparam int unsigned MIN_CHUNK = 8;
   localparam int unsigned MAX_CHUNK = MIN_CHUNK << (NUM_CLS - 1);
endpackage

// File: rtl/pgalloc_class_dec.sv
module pgalloc_class_dec
   import pgalloc_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic [CNT_W-1:0] pages,
   output chunk_cls_e       cls,
   output logic             bad
);
   initial begin
      if (CNT_W < 7) $error("CNT_W must hold counts above 64");
   end

   always_comb begin
      bad = (pages == '0) || (pages > CNT_W'(MAX_CHUNK));
      if (pages <= CNT_W'(8))       cls = CLS_8;
      else if (pages <= CNT_W'(16)) cls = CLS_16;
      else if (pages <= CNT_W'(32)) cls = CLS_32;
      else                          cls = CLS_64;
   end
endmodule

// File: rtl/pgalloc_bitmap.sv
module pgalloc_bitmap
   import pgalloc_pkg::*;
#(
   parameter int MAP_PAGES = 256,
   parameter int IDX_W     = $clog2(MAP_PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] base,
   input  chunk_cls_e       cls,
   input  logic             set_en,
   input  logic             clr_en,
   output logic             chunk_free
);
   logic [MAP_PAGES-1:0]                map_q;
   logic [NUM_CLS-1:0][MAP_PAGES-1:0]   mask_v;
   logic [NUM_CLS-1:0]                  free_v;
   logic [MAP_PAGES-1:0]                mask;

   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      localparam int W = MIN_CHUNK << c;
      localparam logic [MAP_PAGES-1:0] ONES = MAP_PAGES'({W{1'b1}});
      logic [IDX_W-1:0] base_al;
      assign base_al   = base & ~IDX_W'(W - 1);
      assign mask_v[c] = ONES << base_al;
      assign free_v[c] = ~|(map_q & mask_v[c]);
   end

   assign mask       = mask_v[cls];
   assign chunk_free = free_v[cls];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      map_q <= '0;
      else if (set_en) map_q <= map_q | mask;
      else if (clr_en) map_q <= map_q & ~mask;
   end

   // R6: a chunk is only marked in use when it was entirely clear
   a_r6_set_only_free: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> chunk_free);
   // R11: a free never collides with a grant
   a_r11_no_set_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en && clr_en));
   // R2: after a grant the same chunk reads as occupied
   a_r2_chunk_taken: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> (map_q & $past(mask)) == $past(mask));
endmodule

// File: rtl/pgalloc_scan.sv
module pgalloc_scan
   import pgalloc_pkg::*;
#(
   parameter int MAP_PAGES = 256,
   parameter int IDX_W     = $clog2(MAP_PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_bad,
   input  chunk_cls_e       cls_in,
   input  logic             chunk_free,
   output logic [IDX_W-1:0] cur_base,
   output chunk_cls_e       cur_cls,
   output logic             set_en,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic [IDX_W-1:0] grant_idx
);
   localparam int SW = IDX_W + 1;

   logic [IDX_W-1:0] hint_q, cur_q, left_q;
   chunk_cls_e       cls_q;
   logic [SW-1:0]    step_q, step_in, nxt_sum;
   logic [IDX_W-1:0] nxt_cur, start_base, chunks_in;

   assign step_q     = SW'(MIN_CHUNK) << cls_q;
   assign step_in    = SW'(MIN_CHUNK) << cls_in;
   assign nxt_sum    = {1'b0, cur_q} + step_q;
   assign nxt_cur    = (nxt_sum >= SW'(MAP_PAGES)) ? '0 : nxt_sum[IDX_W-1:0];
   assign start_base = hint_q & ~(step_in[IDX_W-1:0] - 1'b1);
   assign chunks_in  = IDX_W'(MAP_PAGES / MIN_CHUNK) >> cls_in;

   assign cur_base = cur_q;
   assign cur_cls  = cls_q;
   assign set_en   = busy && chunk_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         error     <= 1'b0;
         hint_q    <= '0;
         cur_q     <= '0;
         left_q    <= '0;
         cls_q     <= CLS_8;
         grant_idx <= '0;
      end else begin
         done  <= 1'b0;
         error <= 1'b0;
         if (!busy) begin
            if (start_bad) begin
               error <= 1'b1;
            end else if (start) begin
               busy   <= 1'b1;
               cls_q  <= cls_in;
               cur_q  <= start_base;
               left_q <= chunks_in - 1'b1;
            end
         end else if (chunk_free) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            grant_idx <= cur_q;
            hint_q    <= nxt_cur;
         end else if (left_q == '0) begin
            busy  <= 1'b0;
            error <= 1'b1;
         end else begin
            cur_q  <= nxt_cur;
            left_q <= left_q - 1'b1;
         end
      end
   end

   // R9: a search only begins from an accepted request
   a_r9_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start) && !$past(start_bad));
   // R9: a result ends the search
   a_r9_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !busy);
   // R2: grant and error never coincide
   a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   // R3: every grant sits on at least an 8-page boundary
   a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> grant_idx[2:0] == 3'd0);
   // R7: the hint stays put when a search fails
   a_r7_hint_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> $stable(hint_q));
   // R5: the search steps to a fresh chunk every non-final cycle
   a_r5_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !chunk_free && left_q != '0) |=> busy && cur_q != $past(cur_q));
endmodule

// File: rtl/pgalloc_top.sv
module pgalloc_top
   import pgalloc_pkg::*;
#(
   parameter int MAP_PAGES = 256,
   parameter int CNT_W     = 7,
   parameter int IDX_W     = $clog2(MAP_PAGES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   input  logic [CNT_W-1:0] alloc_pages,
   input  logic             free_req,
   input  logic [IDX_W-1:0] free_idx,
   input  logic [1:0]       free_cls,
   output logic             busy,
   output logic             done,
   output logic             error,
   output logic [IDX_W-1:0] grant_idx
);
   initial begin
      if (MAP_PAGES < int'(MAX_CHUNK) || (MAP_PAGES % int'(MAX_CHUNK)) != 0)
         $error("MAP_PAGES must be a positive multiple of 64");
      if (IDX_W < $clog2(MAP_PAGES))
         $error("IDX_W too narrow for MAP_PAGES");
   end

   chunk_cls_e       req_cls, scan_cls, q_cls;
   logic             req_bad, chunk_free, set_en, clr_en;
   logic [IDX_W-1:0] scan_base, q_base;

   pgalloc_class_dec #(.CNT_W(CNT_W)) u_dec (
      .pages (alloc_pages),
      .cls   (req_cls),
      .bad   (req_bad)
   );

   assign clr_en = free_req && !busy && !alloc_req;
   assign q_base = busy ? scan_base : free_idx;
   assign q_cls  = busy ? scan_cls  : chunk_cls_e'(free_cls);

   pgalloc_bitmap #(.MAP_PAGES(MAP_PAGES), .IDX_W(IDX_W)) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .base       (q_base),
      .cls        (q_cls),
      .set_en     (set_en),
      .clr_en     (clr_en),
      .chunk_free (chunk_free)
   );

   pgalloc_scan #(.MAP_PAGES(MAP_PAGES), .IDX_W(IDX_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (alloc_req),
      .start_bad  (alloc_req && req_bad),
      .cls_in     (req_cls),
      .chunk_free (chunk_free),
      .cur_base   (scan_base),
      .cur_cls    (scan_cls),
      .set_en     (set_en),
      .busy       (busy),
      .done       (done),
      .error      (error),
      .grant_idx  (grant_idx)
   );

   // R4: a bad request never starts a search
   a_r4_bad_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && req_bad && !busy) |=> error && !busy);
endmodule

// File: tb/pgalloc_top_bench.sv
module pgalloc_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAP_PAGES  = 256;
   localparam int CNT_W      = 7;
   localparam int IDX_W      = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_req = 1'b0, free_req = 1'b0;
   logic [CNT_W-1:0] alloc_pages = '0;
   logic [IDX_W-1:0] free_idx = '0;
   logic [1:0] free_cls = '0;
   logic busy, done, error;
   logic [IDX_W-1:0] grant_idx;

   int checks = 0, fails = 0;

   typedef struct { bit err; int idx; } exp_t;
   exp_t exp_q[$];
   bit   mdl_map[MAP_PAGES];
   int   mdl_hint = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgalloc_top #(.MAP_PAGES(MAP_PAGES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pgalloc_top (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_pages(alloc_pages),
      .free_req(free_req), .free_idx(free_idx), .free_cls(free_cls),
      .busy(busy), .done(done), .error(error), .grant_idx(grant_idx));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // reference search: returns expected entry and chunks examined
   function automatic exp_t predict(input int pages, output int examined);
      exp_t e; int w, start;
      examined = 0; e.err = 1'b1; e.idx = 0;
      if (pages == 0 || pages > 64) return e;
      w = (pages <= 8) ? 8 : (pages <= 16) ? 16 : (pages <= 32) ? 32 : 64;
      start = mdl_hint - (mdl_hint % w);
      for (int i = 0; i < MAP_PAGES / w; i++) begin
         int b; bit fr;
         b = (start + i * w) % MAP_PAGES;
         examined++;
         fr = 1'b1;
         for (int k = 0; k < w; k++) if (mdl_map[b + k]) fr = 1'b0;
         if (fr) begin
            for (int k = 0; k < w; k++) mdl_map[b + k] = 1'b1;
            mdl_hint = (b + w) % MAP_PAGES;
            e.err = 1'b0; e.idx = b;
            return e;
         end
      end
      return e;
   endfunction

   // monitor: pops the scoreboard on each result pulse
   always @(negedge clk) begin
      if (rst_n && (done || error)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected result", int'(done), 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(error == e.err, "R4/R8 error flag", int'(error), int'(e.err));
            if (!e.err) check(grant_idx == IDX_W'(e.idx), "R2/R5/R6 grant index",
                              int'(grant_idx), e.idx);
         end
      end
   end

   task automatic do_alloc(input int pages, input bit poke_busy);
      exp_t e; int exam, lat, exp_lat;
      e = predict(pages, exam);
      exp_lat = e.err && exam == 0 ? 1 : 1 + exam;
      @(negedge clk);
      alloc_req = 1'b1; alloc_pages = CNT_W'(pages);
      exp_q.push_back(e);
      lat = 0;
      forever begin
         @(negedge clk);
         lat++;
         if (lat == 1) alloc_req = 1'b0;
         if (poke_busy && lat == 2) begin alloc_req = 1'b1; alloc_pages = 7'd1; end
         if (poke_busy && lat == 3) alloc_req = 1'b0;
         if (done || error) break;
         if (lat == 1) check(busy, "R9 busy during search", int'(busy), 1);
         if (lat > 200) break;
      end
      alloc_req = 1'b0;
      check(lat == exp_lat, "R8/R9 latency", lat, exp_lat);
      @(negedge clk);
      check(!busy && !done && !error, "R11 idle after result", int'(busy), 0);
   endtask

   task automatic do_free(input int idx, input int cls);
      int w;
      w = 8 << cls;
      for (int k = 0; k < w; k++) mdl_map[(idx - idx % w) + k] = 1'b0;
      @(negedge clk);
      free_req = 1'b1; free_idx = IDX_W'(idx); free_cls = 2'(cls);
      @(negedge clk);
      free_req = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R1 busy after reset", int'(busy), 0);
      check(!done, "R1 done after reset", int'(done), 0);
      check(!error, "R1 error after reset", int'(error), 0);
      do_alloc(1, 0);    // R3 8-page class at 0
      do_alloc(8, 0);    // R7 hint moved to 8
      do_alloc(9, 0);    // R3 16-page class
      do_alloc(20, 0);   // R3 32-page class
      do_alloc(64, 0);   // R3 64-page class
      do_alloc(0, 0);    // R4 zero pages
      do_alloc(65, 0);   // R4 too many pages
      do_free(0, 0);     // R10 free leaves hint at 128
      do_alloc(3, 0);    // R10 grant at 128, not at freed 0
      do_alloc(64, 0);   // R5 start aligned down, finds 192, hint wraps
      do_alloc(5, 0);    // R7 wrap of hint to 0 reuses freed chunk
      do_alloc(64, 1);   // R8 out of resources, R11 alloc while busy ignored
      do_alloc(32, 0);   // R5 finds 160
      do_alloc(16, 0);   // R5 wraps past end, finds 144
      do_free(70, 3);    // R10 unaligned index frees 64..127
      do_alloc(40, 0);   // R6 lands on freed 64-chunk
      @(negedge clk);
      free_req = 1'b1; alloc_req = 1'b1; alloc_pages = 7'd0; free_idx = 8'd64; free_cls = 2'd3;
      exp_q.push_back('{err: 1'b1, idx: 0});
      @(negedge clk);
      free_req = 1'b0; alloc_req = 1'b0;
      do_alloc(33, 0);   // R11 free beside alloc_req was ignored: 64 chunk still taken
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule